// File: doc/BRIEF.md
# Strobe-Supervised Watchdog with Selectable Timeout

This block supervises a processor through a single strobe wire. While the processor is healthy it drives a high-to-low transition on the strobe at regular intervals, and each such transition restarts an internal millisecond count. If the count reaches the selected timeout first, the block drives its reset outputs active for a fixed 250 ms pulse. It then releases them and starts timing again from zero. The active-high and active-low reset outputs are always complements of each other. A one-cycle event flag marks each expiry.

Time is counted in 1 ms ticks from a prescaler of `CLK_PER_MS` clock cycles. A two-bit select code picks the timeout: 150 ms, 600 ms or 1200 ms, and the spare code also gives 600 ms. The code is captured only when the count restarts. An external reset-active input reports every other reset source, for example a supply monitor or a push-button debouncer. While it is high, the reset outputs are active and the watchdog does not count. Counting begins only after all reset sources have gone inactive. The strobe and the external reset input are expected to be synchronous to `clk`.

Top module: `strobe_watchdog`

## Requirements
- R1: With select code 00, 01, 10 or 11 the timeout is 150, 600, 1200 or 600 ms respectively. One ms is `CLK_PER_MS` clocks. Once counting starts at clock edge E with no strobe fall, `rstOut` goes high after edge E + timeout_ms*CLK_PER_MS. Counting starts at the edge where `extRstActive` is first sampled low.
- R2: Only a high-to-low transition of `strobe` restarts the count. If `strobe` is first driven low in the cycle after edge C, the count is cleared at edge C+2 and expiry moves to edge C+2 + timeout_ms*CLK_PER_MS. A rising edge or a steady level has no effect on the expiry edge.
- R3: Each expiry holds `rstOut` high for exactly 250*CLK_PER_MS clock cycles, unless `extRstActive` intervenes.
- R4: `rstOutN` is always the complement of `rstOut`.
- R5: `timeoutEvt` is high for exactly one cycle per expiry. That cycle is the first cycle in which `rstOut` is high.
- R6: While `extRstActive` is high, `rstOut` is high from the next cycle on and no expiry can occur. Counting restarts from zero after release, as in R1.
- R7: A change of `toSel` during counting does not alter the running timeout. The new code takes effect at the next restart, whether that comes from a strobe fall, the end of a pulse or a release of the external reset.
- R8: Strobe falls during the reset pulse are ignored. The pulse keeps its full length. The count restarts from zero at the edge that ends the pulse, so the next expiry comes timeout_ms*CLK_PER_MS edges later.
- R9: While `rstN` is low, `rstOut` is 1, `rstOutN` is 0 and `timeoutEvt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the block's flops |
| strobe | input | 1 | Processor keep-alive strobe; falling edges restart the count |
| toSel | input | 2 | Timeout select code (00:150 ms, 01:600 ms, 10:1200 ms, 11:600 ms) |
| extRstActive | input | 1 | High while any other reset source is active |
| rstOut | output | 1 | Reset output, active high |
| rstOutN | output | 1 | Reset output, active low |
| timeoutEvt | output | 1 | One-cycle pulse at each watchdog expiry |

## Verification
**Expiry timing.** Expiry is due exactly timeout_ms*CLK_PER_MS edges after the restart edge. That restart edge is the first edge seeing the external reset low, the edge ending a pulse, or the second edge after the strobe is driven low.

**How the bench samples.** The bench counts posedges from its own stimulus and samples on the following negedge, then compares the count with these formulas.

**Other outputs.** The event flag is checked on the same negedge as the rise of `rstOut` and again one cycle later. The pulse width is counted in whole cycles while `rstOut` stays high. The external reset input is checked one cycle after it is raised.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2
  } wdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // zero prescaler and ms count
    logic load;    // capture the timeout select code
    logic run;     // advance the prescaler and ms count
  } wdCtrl_t;

  // Status from datapath to control
  typedef struct packed {
    logic timeoutHit;  // last tick of the selected timeout
    logic pulseDone;   // last tick of the reset pulse
    logic strobeFall;  // high-to-low transition seen on strobe
  } wdStat_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CLK_PER_MS = 50000,
  parameter int SHORT_MS   = 150,
  parameter int MID_MS     = 600,
  parameter int LONG_MS    = 1200,
  parameter int PULSE_MS   = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strobe,
  input  logic [1:0] toSel,
  input  wdCtrl_t    ctrl,
  output wdStat_t    stat
);

  localparam int MAX_TO = (SHORT_MS > MID_MS)
                        ? ((SHORT_MS > LONG_MS) ? SHORT_MS : LONG_MS)
                        : ((MID_MS > LONG_MS) ? MID_MS : LONG_MS);
  localparam int MAX_MS = (MAX_TO > PULSE_MS) ? MAX_TO : PULSE_MS;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  logic [CNT_W-1:0] msCount;
  logic [CNT_W-1:0] limitMs;
  logic             preWrap;
  logic             stbNow;
  logic             stbLast;

  function automatic logic [CNT_W-1:0] selToMs(input logic [1:0] sel);
    case (sel)
      2'b00:   return CNT_W'(SHORT_MS);
      2'b10:   return CNT_W'(LONG_MS);
      default: return CNT_W'(MID_MS);
    endcase
  endfunction

  // Millisecond prescaler; degenerates to a constant tick for one clock per ms
  generate
    if (CLK_PER_MS > 1) begin : gPrescale
      localparam int PRE_W = $clog2(CLK_PER_MS);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);
      logic [PRE_W-1:0] preCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (ctrl.clear) begin
          preCnt <= '0;
        end else if (ctrl.run) begin
          preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
        end
      end

      assign preWrap = (preCnt == PRE_LAST);
    end else begin : gNoPrescale
      assign preWrap = 1'b1;
    end
  endgenerate

  // Millisecond counter, shared by timeout and pulse phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCount <= '0;
    end else if (ctrl.clear) begin
      msCount <= '0;
    end else if (ctrl.run && preWrap) begin
      msCount <= msCount + 1'b1;
    end
  end

  // Timeout limit captured at each restart
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitMs <= CNT_W'(MID_MS);
    end else if (ctrl.load) begin
      limitMs <= selToMs(toSel);
    end
  end

  // Strobe edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbNow  <= 1'b1;
      stbLast <= 1'b1;
    end else begin
      stbNow  <= strobe;
      stbLast <= stbNow;
    end
  end

  assign stat.strobeFall = stbLast & ~stbNow;
  assign stat.timeoutHit = preWrap && (msCount == limitMs - 1'b1);
  assign stat.pulseDone  = preWrap && (msCount == CNT_W'(PULSE_MS - 1));

endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    extRstActive,
  input  wdStat_t stat,
  output wdCtrl_t ctrl,
  output logic    rstOut,
  output logic    timeoutEvt
);

  wdState_t state;
  wdState_t stateNext;
  logic     expire;
  logic     evtQ;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    expire    = 1'b0;
    unique case (state)
      ST_HOLD: begin
        ctrl.clear = 1'b1;
        if (!extRstActive) begin
          stateNext = ST_RUN;
          ctrl.load = 1'b1;
        end
      end
      ST_RUN: begin
        if (extRstActive) begin
          stateNext  = ST_HOLD;
          ctrl.clear = 1'b1;
        end else if (stat.timeoutHit) begin
          stateNext  = ST_PULSE;
          ctrl.clear = 1'b1;
          expire     = 1'b1;
        end else if (stat.strobeFall) begin
          ctrl.clear = 1'b1;
          ctrl.load  = 1'b1;
        end else begin
          ctrl.run = 1'b1;
        end
      end
      ST_PULSE: begin
        if (extRstActive) begin
          stateNext  = ST_HOLD;
          ctrl.clear = 1'b1;
        end else if (stat.pulseDone) begin
          stateNext  = ST_RUN;
          ctrl.clear = 1'b1;
          ctrl.load  = 1'b1;
        end else begin
          ctrl.run = 1'b1;
        end
      end
      default: begin
        stateNext  = ST_HOLD;
        ctrl.clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HOLD;
      evtQ  <= 1'b0;
    end else begin
      state <= stateNext;
      evtQ  <= expire;
    end
  end

  assign rstOut     = (state != ST_RUN);
  assign timeoutEvt = evtQ;

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
  import wdog_pkg::*;
#(
  parameter int CLK_PER_MS = 50000,
  parameter int SHORT_MS   = 150,
  parameter int MID_MS     = 600,
  parameter int LONG_MS    = 1200,
  parameter int PULSE_MS   = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strobe,
  input  logic [1:0] toSel,
  input  logic       extRstActive,
  output logic       rstOut,
  output logic       rstOutN,
  output logic       timeoutEvt
);

  wdCtrl_t ctrl;
  wdStat_t stat;
  logic    rstInt;

  wdog_datapath #(
    .CLK_PER_MS(CLK_PER_MS),
    .SHORT_MS  (SHORT_MS),
    .MID_MS    (MID_MS),
    .LONG_MS   (LONG_MS),
    .PULSE_MS  (PULSE_MS)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .toSel (toSel),
    .ctrl  (ctrl),
    .stat  (stat)
  );

  wdog_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .extRstActive(extRstActive),
    .stat        (stat),
    .ctrl        (ctrl),
    .rstOut      (rstInt),
    .timeoutEvt  (timeoutEvt)
  );

  assign rstOut  = rstInt;
  assign rstOutN = ~rstInt;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CLK_PER_MS = 50000,
  parameter int PULSE_MS   = 250
) (
  input logic clk,
  input logic rstN,
  input logic extRstActive,
  input logic rstOut,
  input logic timeoutEvt
);

  int   hiLen;
  logic sawExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLen  <= 0;
      sawExt <= 1'b1;
    end else begin
      hiLen  <= rstOut ? hiLen + 1 : 0;
      sawExt <= rstOut ? (sawExt | extRstActive) : extRstActive;
    end
  end

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEvt |=> !timeoutEvt);  // R5

  AST_EVT_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEvt |-> (rstOut && !$past(rstOut)));  // R5

  AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    extRstActive |=> rstOut);  // R6

  AST_EXT_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    extRstActive |=> !timeoutEvt);  // R6

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rstOut) && !sawExt) |-> (hiLen == PULSE_MS * CLK_PER_MS));  // R3

endmodule

bind strobe_watchdog wdog_checker #(
  .CLK_PER_MS(CLK_PER_MS),
  .PULSE_MS  (PULSE_MS)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .extRstActive(extRstActive),
  .rstOut      (rstOut),
  .timeoutEvt  (timeoutEvt)
);

// File: tb/sim_strobe_watchdog.sv
module sim_strobe_watchdog;

  localparam int N  = 4;
  localparam int PW = 250 * N;
  localparam int NV = 8;
  localparam int VSEL [NV] = '{0, 0, 1, 1, 2, 3, 3, 2};
  localparam int VGAP [NV] = '{500, 700, 2300, 2500, 4700, 2300, 2500, 5000};

  logic       clk = 1'b0;
  logic       rstN;
  logic       strobe;
  logic [1:0] toSel;
  logic       extRstActive;
  logic       rstOut;
  logic       rstOutN;
  logic       timeoutEvt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  strobe_watchdog #(.CLK_PER_MS(N)) u0 (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .toSel       (toSel),
    .extRstActive(extRstActive),
    .rstOut      (rstOut),
    .rstOutN     (rstOutN),
    .timeoutEvt  (timeoutEvt)
  );

  function automatic int msFor(input int sel);
    case (sel)
      0:       return 150;
      2:       return 1200;
      default: return 600;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Returns at a negedge with extRstActive low; the next posedge starts counting
  task automatic holdExt(input int sel);
    @(negedge clk);
    toSel = 2'(sel);
    extRstActive = 1'b1;
    repeat (3) @(negedge clk);
    extRstActive = 1'b0;
  endtask

  task automatic edgesToRise(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!rstOut && n < 20000);
  endtask

  initial begin
    int n;
    int w;
    int fired;
    rstN = 1'b0;
    strobe = 1'b1;
    toSel = 2'b00;
    extRstActive = 1'b1;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 rstOut in reset", int'(rstOut), 1);
    chk("R9 rstOutN in reset", int'(rstOutN), 0);
    chk("R9 timeoutEvt in reset", int'(timeoutEvt), 0);
    rstN = 1'b1;

    // Vector table: R1 timeout thresholds, R2 regular strobing keeps reset away
    for (int v = 0; v < NV; v++) begin
      holdExt(VSEL[v]);
      fired = 0;
      for (int k = 0; k < 3; k++) begin
        for (int c = 0; c < VGAP[v] - 1; c++) begin
          @(negedge clk);
          if (rstOut) fired = 1;
        end
        strobe = 1'b0;
        @(negedge clk);
        strobe = 1'b1;
      end
      chk($sformatf("R1 R2 vector %0d reset fired", v), fired,
          (VGAP[v] > msFor(VSEL[v]) * N) ? 1 : 0);
    end

    // R1 exact expiry per code, R3 pulse width, R4, R5
    for (int s = 0; s < 4; s++) begin
      holdExt(s);
      edgesToRise(n);
      chk($sformatf("R1 expiry edges sel %0d", s), n, msFor(s) * N + 1);
      chk("R5 event at rise", int'(timeoutEvt), 1);
      chk("R4 rstOutN during pulse", int'(rstOutN), 0);
      @(negedge clk);
      chk("R5 event one cycle", int'(timeoutEvt), 0);
      w = 1;
      while (rstOut && w < 20000) begin
        w++;
        @(negedge clk);
      end
      chk($sformatf("R3 pulse width sel %0d", s), w, PW);
      chk("R4 rstOutN after pulse", int'(rstOutN), 1);
    end
    // R8: after the last pulse the count restarted from zero
    edgesToRise(n);
    chk("R8 re-expiry after pulse", n, msFor(3) * N);

    // R2 exact restart point of a falling strobe
    holdExt(0);
    repeat (100) @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    strobe = 1'b1;
    edgesToRise(n);
    chk("R2 expiry after strobe fall", 101 + n, 102 + msFor(0) * N);

    // R2 a rising edge and a steady low level do not restart
    strobe = 1'b0;
    holdExt(0);
    repeat (200) @(negedge clk);
    strobe = 1'b1;
    edgesToRise(n);
    chk("R2 rising edge ignored", 200 + n, msFor(0) * N + 1);

    // R7 select change mid-count is deferred
    holdExt(0);
    repeat (50) @(negedge clk);
    toSel = 2'b10;
    edgesToRise(n);
    chk("R7 running timeout unchanged", 50 + n, msFor(0) * N + 1);
    holdExt(0);
    repeat (50) @(negedge clk);
    toSel = 2'b10;
    repeat (50) @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    strobe = 1'b1;
    edgesToRise(n);
    chk("R7 new code loaded at restart", 101 + n, 102 + msFor(2) * N);

    // R8 strobe falls during the pulse are ignored
    holdExt(0);
    edgesToRise(n);
    w = 1;
    @(negedge clk);
    while (rstOut && w < 20000) begin
      w++;
      strobe = ((w % 100) == 50 && w < 900) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    strobe = 1'b1;
    chk("R8 pulse width with strobes", w, PW);
    edgesToRise(n);
    chk("R8 count restarted after pulse", n, msFor(0) * N);

    // R6 external reset holds outputs and stops counting
    holdExt(0);
    repeat (300) @(negedge clk);
    extRstActive = 1'b1;
    @(negedge clk);
    chk("R6 rstOut follows external", int'(rstOut), 1);
    fired = 0;
    for (int c = 0; c < 800; c++) begin
      @(negedge clk);
      if (timeoutEvt || !rstOut) fired = 1;
    end
    chk("R6 no expiry while held", fired, 0);
    extRstActive = 1'b0;
    edgesToRise(n);
    chk("R6 count from zero after release", n, msFor(0) * N + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule